// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen architectural registers of a 32-bit processor core: R0 to R15. What a register number selects depends on the current operating mode. Seven modes are recognised. User and system mode use one common set. Interrupt, supervisor, abort and undefined mode each keep a private stack pointer (R13) and a private link register (R14). Fast-interrupt mode keeps private copies of R8 through R14, so its handler can run without saving the interrupted code's upper registers. Every other register number resolves to the shared storage.

Reads are combinational on any number of ports, set by a parameter (two by default). There is one synchronous write port. All ports take a 4-bit register number and are translated through the current mode. R15 is the program counter and lives in its own register. It advances by a fixed step when the core asks, and it is reloaded when R15 is written, which is how a branch is taken.

An exception-entry strobe stores a return address into the link register of the mode being entered. It does so in the same clock edge at which the mode input switches to that mode.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset sets the program counter to 0. Reading R15 on a port after reset returns 0. General registers are not cleared.
- R2: Mode codes are 5 bits: user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. User and system mode see the same R0 to R14.
- R3: In fast-interrupt mode, R0 to R7 are the shared registers, and R8 to R14 are storage that only fast-interrupt mode sees.
- R4: In interrupt, supervisor, abort and undefined mode, R0 to R12 are the shared registers. R13 and R14 are distinct for each of these four modes and are separate from the user and fast-interrupt copies.
- R5: A mode code outside the seven listed behaves as user mode for reads, writes and exception entry.
- R6: Reading R15 on any read port returns the current program counter.
- R7: A write to R15 loads the program counter at the next edge. It takes priority over the advance request in the same cycle.
- R8: With the advance input high and no R15 write, the program counter grows by 4 at each edge.
- R9: A read that addresses the physical register being written in the same cycle returns the old value. The new value is visible after the edge.
- R10: The exception strobe writes its return address into R14 of the target mode given by the strobe, not by the current mode. If the write port targets the same physical register in that cycle, the strobe's value is kept.
- R11: The read ports are independent. Each returns the register its own address selects in the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current operating mode code |
| rd_addr | input | NRD*4 | Read register numbers, port k in bits [4k+3:4k] |
| rd_data | output | NRD*XLEN | Read data, port k in bits [XLEN*k+XLEN-1:XLEN*k] |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | XLEN | Write data |
| pc_adv | input | 1 | Advance the program counter by one step |
| exc_valid | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Mode being entered |
| exc_ret | input | XLEN | Return address for the target link register |
| pc | output | XLEN | Current program counter |

## Verification
The bench fills every register from every mode's view, including an unlisted mode code, and then reads all fifteen general registers in every mode on both ports. A model that keys storage by owning bank predicts each value. A mapping that aliases one mode's R13 or R14 onto another's shows a foreign value, and so does a fast-interrupt bank that stops at R12. A missing R0 to R7 share in fast-interrupt mode shows up the same way. Same-cycle cases are also driven: a read of the register being written, which would show the new data if writes passed through; an R15 write against an advance, where the wrong priority gives an extra step; and an exception strobe that collides with a port write, where the wrong priority loses the return address or drops it into the current mode's link register.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  localparam int LREG_W = 4;
  localparam int MODE_W = 5;
  localparam int NPHYS  = 30;
  localparam int PIDX_W = $clog2(NPHYS);

  typedef logic [PIDX_W-1:0] pidx_t;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  // Storage layout: 0..14 shared, 15..19 fast-interrupt R8..R12,
  // then one R13/R14 pair per banking mode starting at 20.
  localparam int FIQ_HI_BASE = 15;
  localparam int PAIR_BASE   = 20;

  // Pair slot of the R13/R14 bank, -1 for the shared pair.
  function automatic int pair_slot(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return 0;
      M_IRQ:   return 1;
      M_SVC:   return 2;
      M_ABT:   return 3;
      M_UND:   return 4;
      default: return -1;
    endcase
  endfunction

  function automatic pidx_t phys_of(input logic [MODE_W-1:0] m,
                                    input logic [LREG_W-1:0] r);
    int ri;
    int slot;
    ri   = int'(r);
    slot = pair_slot(m);
    if (ri < 8 || ri == 15)
      return pidx_t'(ri < 8 ? ri : 0);
    else if (ri < 13)
      return pidx_t'(m == M_FIQ ? FIQ_HI_BASE + ri - 8 : ri);
    else if (slot < 0)
      return pidx_t'(ri);
    else
      return pidx_t'(PAIR_BASE + 2 * slot + ri - 13);
  endfunction

endpackage

// File: rtl/brf_map.sv
module brf_map
  import banked_rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [LREG_W-1:0] lreg,
  output pidx_t             pidx
);
  assign pidx = phys_of(mode, lreg);
endmodule

// File: rtl/brf_store.sv
module brf_store
  import banked_rf_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NRD  = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  pidx_t                 widx,
  input  logic [XLEN-1:0]       wdata,
  input  logic                  ewe,
  input  pidx_t                 eidx,
  input  logic [XLEN-1:0]       edata,
  input  logic [NRD*PIDX_W-1:0] ridx,
  output logic [NRD*XLEN-1:0]   rdata
);
  logic [XLEN-1:0] mem [NPHYS];

  // The exception write comes last, so it wins on a shared index.
  always_ff @(posedge clk) begin
    if (we)  mem[widx] <= wdata;
    if (ewe) mem[eidx] <= edata;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata[k*XLEN +: XLEN] = mem[ridx[k*PIDX_W +: PIDX_W]];
  end
endmodule

// File: rtl/brf_pc.sv
module brf_pc #(
  parameter int          XLEN     = 32,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [XLEN-1:0] ld_val,
  input  logic            adv,
  output logic [XLEN-1:0] pc_q
);
  function automatic logic [XLEN-1:0] step_pc(input logic [XLEN-1:0] cur);
    return cur + XLEN'(PC_STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      pc_q <= XLEN'(RESET_PC);
    else if (ld)  pc_q <= ld_val;
    else if (adv) pc_q <= step_pc(pc_q);
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NRD      = 2,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4:0]          mode,
  input  logic [NRD*4-1:0]    rd_addr,
  output logic [NRD*XLEN-1:0] rd_data,
  input  logic                wr_en,
  input  logic [3:0]          wr_addr,
  input  logic [XLEN-1:0]     wr_data,
  input  logic                pc_adv,
  input  logic                exc_valid,
  input  logic [4:0]          exc_mode,
  input  logic [XLEN-1:0]     exc_ret,
  output logic [XLEN-1:0]     pc
);
  localparam logic [LREG_W-1:0] PC_REG = 4'd15;
  localparam logic [LREG_W-1:0] LR_REG = 4'd14;

  // Named internal events
  logic                  pc_wr_hit;
  logic                  gpr_wr_hit;
  pidx_t                 w_idx;
  pidx_t                 e_idx;
  logic [NRD*PIDX_W-1:0] r_idx;
  logic [NRD*XLEN-1:0]   store_rd;

  assign pc_wr_hit  = wr_en && (wr_addr == PC_REG);
  assign gpr_wr_hit = wr_en && (wr_addr != PC_REG);

  brf_map u_wmap (.mode(mode),     .lreg(wr_addr), .pidx(w_idx));
  brf_map u_emap (.mode(exc_mode), .lreg(LR_REG),  .pidx(e_idx));

  for (genvar k = 0; k < NRD; k++) begin : g_port
    logic [LREG_W-1:0] a;
    assign a = rd_addr[k*LREG_W +: LREG_W];
    brf_map u_rmap (.mode(mode), .lreg(a), .pidx(r_idx[k*PIDX_W +: PIDX_W]));
    assign rd_data[k*XLEN +: XLEN] = (a == PC_REG) ? pc : store_rd[k*XLEN +: XLEN];
  end

  brf_store #(.XLEN(XLEN), .NRD(NRD)) u_store (
    .clk  (clk),
    .we   (gpr_wr_hit),
    .widx (w_idx),
    .wdata(wr_data),
    .ewe  (exc_valid),
    .eidx (e_idx),
    .edata(exc_ret),
    .ridx (r_idx),
    .rdata(store_rd)
  );

  brf_pc #(.XLEN(XLEN), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst   (rst),
    .ld    (pc_wr_hit),
    .ld_val(wr_data),
    .adv   (pc_adv),
    .pc_q  (pc)
  );
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int          XLEN     = 32,
  parameter int          NRD      = 2,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input logic                clk,
  input logic                rst,
  input logic [4:0]          mode,
  input logic [NRD*4-1:0]    rd_addr,
  input logic [NRD*XLEN-1:0] rd_data,
  input logic                wr_en,
  input logic [3:0]          wr_addr,
  input logic [XLEN-1:0]     wr_data,
  input logic                pc_adv,
  input logic                exc_valid,
  input logic [4:0]          exc_mode,
  input logic [XLEN-1:0]     exc_ret,
  input logic [XLEN-1:0]     pc,
  input logic                pc_wr_hit
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  AST_PC_RESET: assert property (@(posedge clk)
    rst_q |-> pc == XLEN'(RESET_PC)); // R1

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_wr_hit)) |-> pc == $past(wr_data)); // R7

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_adv) && !$past(pc_wr_hit))
      |-> pc == $past(pc) + XLEN'(PC_STEP)); // R8

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pc_adv) && !$past(pc_wr_hit)) |-> $stable(pc)); // R8

  AST_RD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(mode) && $stable(rd_addr[3:0]) && !$past(wr_en)
      && !$past(exc_valid) && rd_addr[3:0] != 4'd15)
      |-> $stable(rd_data[XLEN-1:0])); // R9

  AST_EXC_LR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exc_valid) && mode == $past(exc_mode)
      && rd_addr[3:0] == 4'd14)
      |-> rd_data[XLEN-1:0] == $past(exc_ret)); // R10
endmodule

bind banked_regfile brf_checker #(
  .XLEN(XLEN), .NRD(NRD), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
) u_brf_checker (
  .clk(clk), .rst(rst), .mode(mode), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc_adv(pc_adv),
  .exc_valid(exc_valid), .exc_mode(exc_mode), .exc_ret(exc_ret), .pc(pc),
  .pc_wr_hit(pc_wr_hit)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int  XLEN   = 32;
  localparam int  NRD    = 2;
  localparam time PERIOD = 10;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00000, BAD2 = 5'b10110;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [4:0]          mode = USR;
  logic [NRD*4-1:0]    rd_addr = '0;
  logic [NRD*XLEN-1:0] rd_data;
  logic                wr_en = 1'b0;
  logic [3:0]          wr_addr = '0;
  logic [XLEN-1:0]     wr_data = '0;
  logic                pc_adv = 1'b0;
  logic                exc_valid = 1'b0;
  logic [4:0]          exc_mode = USR;
  logic [XLEN-1:0]     exc_ret = '0;
  logic [XLEN-1:0]     pc;

  int tests = 0;
  int fails = 0;
  logic [XLEN-1:0] mdl [0:127];
  logic [XLEN-1:0] exp_pc;
  logic [4:0] mlist [9];

  always #(PERIOD/2) clk = ~clk;

  banked_regfile #(.XLEN(XLEN), .NRD(NRD)) i_banked_regfile (.*);

  // Model key: owning bank times 16 plus register number.
  function automatic int key(input logic [4:0] m, input int r);
    int b;
    b = 0;
    if (m == FIQ && r >= 8) b = 1;
    else if (r >= 13) begin
      if (m == IRQ) b = 2;
      if (m == SVC) b = 3;
      if (m == ABT) b = 4;
      if (m == UND) b = 5;
    end
    return b * 16 + r;
  endfunction

  function automatic logic [XLEN-1:0] expect_of(input logic [4:0] m, input int r);
    return (r == 15) ? exp_pc : mdl[key(m, r)];
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input int r, input logic [XLEN-1:0] v);
    @(negedge clk);
    mode = m; wr_en = 1'b1; wr_addr = 4'(r); wr_data = v;
    @(posedge clk); #1;
    if (r == 15) exp_pc = v; else mdl[key(m, r)] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd2(input string req, input logic [4:0] m, input int ra, input int rb);
    @(negedge clk);
    mode = m; rd_addr = {4'(rb), 4'(ra)};
    #1;
    check(req, rd_data[XLEN-1:0],    expect_of(m, ra));
    check(req, rd_data[2*XLEN-1:XLEN], expect_of(m, rb));
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mlist = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, BAD, BAD2};
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    exp_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 / R6: PC cleared, seen on both ports
    rd_addr = {4'd15, 4'd15}; #1;
    check("R1", pc, 32'h0);
    check("R6", rd_data[XLEN-1:0], 32'h0);
    check("R6", rd_data[2*XLEN-1:XLEN], 32'h0);

    // R2..R5, R11: two fill orders, then full read sweep
    for (int pass = 0; pass < 2; pass++) begin
      for (int mi = 0; mi < 9; mi++) begin
        for (int r = 0; r < 15; r++) begin
          logic [4:0] m;
          m = mlist[pass == 0 ? mi : 8 - mi];
          wr(m, (pass == 0) ? r : 14 - r, {8'(pass + 1), 3'b0, m, 8'(r), 8'hA5});
        end
      end
      for (int mi = 0; mi < 9; mi++)
        for (int r = 0; r < 15; r++)
          rd2("R2 R3 R4 R5 R11 sweep", mlist[mi], r, 14 - r);
    end

    // R3 / R4: distinct banked values per mode
    for (int mi = 0; mi < 6; mi++) begin
      wr(mlist[mi], 13, 32'h1300_0000 + 32'(mi));
      wr(mlist[mi], 14, 32'h1400_0000 + 32'(mi));
      wr(mlist[mi], 12, 32'h1200_0000 + 32'(mi));
    end
    for (int mi = 0; mi < 9; mi++) begin
      rd2("R3 R4 banked pair", mlist[mi], 13, 14);
      rd2("R3 R4 R12", mlist[mi], 12, 7);
    end

    // R9: read during write returns old, then new
    @(negedge clk);
    mode = IRQ; rd_addr = {4'd5, 4'd13};
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hDEAD_0013;
    #1;
    check("R9 old value", rd_data[XLEN-1:0], mdl[key(IRQ, 13)]);
    @(posedge clk); #1;
    mdl[key(IRQ, 13)] = 32'hDEAD_0013;
    check("R9 new value", rd_data[XLEN-1:0], 32'hDEAD_0013);
    @(negedge clk); wr_en = 1'b0;

    // R8: advance five times
    pc_adv = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      exp_pc = exp_pc + 32'd4;
      check("R8 step", pc, exp_pc);
    end

    // R7: write beats advance, then stepping resumes
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd15; wr_data = 32'h0000_8000; mode = SVC;
    @(posedge clk); #1;
    check("R7 load", pc, 32'h0000_8000);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    check("R8 after load", pc, 32'h0000_8004);
    @(negedge clk); pc_adv = 1'b0;
    exp_pc = pc;
    rd_addr = {4'd15, 4'd0}; #1;
    check("R6 port1", rd_data[2*XLEN-1:XLEN], exp_pc);

    // R10: strobe collides with port write to same register
    @(negedge clk);
    mode = SVC; exc_valid = 1'b1; exc_mode = SVC; exc_ret = 32'hE000_0001;
    wr_en = 1'b1; wr_addr = 4'd14; wr_data = 32'hBAD0_BAD0;
    @(posedge clk); #1;
    mdl[key(SVC, 14)] = 32'hE000_0001;
    @(negedge clk); exc_valid = 1'b0; wr_en = 1'b0;
    rd2("R10 collision", SVC, 14, 13);
    rd2("R10 other banks", IRQ, 14, 13);

    // R10: target mode from strobe, current mode user; port write elsewhere
    @(negedge clk);
    mode = USR; exc_valid = 1'b1; exc_mode = FIQ; exc_ret = 32'hE000_0002;
    wr_en = 1'b1; wr_addr = 4'd14; wr_data = 32'h0000_0E14;
    @(posedge clk); #1;
    mdl[key(FIQ, 14)] = 32'hE000_0002;
    mdl[key(USR, 14)] = 32'h0000_0E14;
    @(negedge clk); exc_valid = 1'b0; wr_en = 1'b0;
    rd2("R10 fiq lr", FIQ, 14, 8);
    rd2("R10 usr lr kept", USR, 14, 13);

    // R5: strobe with unlisted mode lands in user R14
    @(negedge clk);
    mode = USR; exc_valid = 1'b1; exc_mode = BAD2; exc_ret = 32'hE000_0003;
    @(posedge clk); #1;
    mdl[key(USR, 14)] = 32'hE000_0003;
    @(negedge clk); exc_valid = 1'b0;
    rd2("R5 exc unlisted", SYS, 14, 13);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule